// File: doc/BRIEF.md
# Run-time RAM rewrite controller

This block lets a host replace a run of words in a 64-entry offset or coefficient RAM while the processing engine that reads that RAM keeps executing. The host sends serial frames. A staging command followed by up to sixteen 24-bit words fills a local buffer. A commit command followed by a start address then hands those words to the RAM write port.

The block never writes all words at once. Word k is released only in the cycle after the engine's live execution address equals start address plus k. Words are released strictly in address order, so a later location is not touched until every earlier one has been written. The engine therefore never runs through a half-updated group.

The ready flag drops once the commit is accepted. It rises again only after every staged word has been written and a minimum busy time has passed. The minimum busy time grows as fewer words are staged. Commands that arrive while the flag is low are discarded.

Top module: `rram_rewrite_ctrl`

## Requirements
- R1: After reset, rdy_o is 1 and ram_we_o is 0, and no write occurs until a commit is accepted.
- R2: Serial bits are taken MSB first on rising sclk_i edges while req_ni is 0. A frame ended early by raising req_ni discards its partial byte, and the next frame starts a fresh byte.
- R3: The first byte of a frame is a command. Command 0x98 empties the staging buffer and then stages each following group of three bytes as one 24-bit word, with the first byte becoming bits 23..16 and the last byte becoming bits 7..0.
- R4: At most 16 words are staged. Any further words in the same staging frame are ignored.
- R5: Command 0x94 is followed by an address byte, and its bits 5..0 give the start address. rdy_o stays 1 after the command byte alone and goes to 0 within a few cycles after the address byte.
- R6: Staged word k is written to address start+k. ram_we_o pulses for one cycle, and ram_waddr_o equals the value exec_addr_i had one cycle earlier.
- R7: Writes occur in increasing address order. No location is written while an earlier staged location of the same commit is still pending.
- R8: rdy_o returns to 1 only after all writes of the commit are done and at least (16−n)×2 cycles after it fell, where n is the number of staged words.
- R9: Command 0x94 with no staged words, and any command byte other than 0x98 or 0x94 together with the rest of its frame, cause no write and leave rdy_o at 1.
- R10: Staged words whose target would exceed address 63 are dropped.
- R11: Frames received while rdy_o is 0 are ignored in full.
- R12: An accepted commit empties the staging buffer, so a repeated 0x94 without a new staging frame does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 1 | Serial frame request, active low |
| sclk_i | input | 1 | Serial bit clock |
| sdi_i | input | 1 | Serial data, MSB first |
| exec_addr_i | input | 6 | Engine's current execution address |
| rdy_o | output | 1 | 1 when no commit is pending |
| ram_we_o | output | 1 | RAM write strobe, one cycle per word |
| ram_waddr_o | output | 6 | RAM write address |
| ram_wdata_o | output | 24 | RAM write data |

## Verification
Some internal faults show up at the write port. A wrong commit index or base shows as a write whose address differs from the execution address of the previous cycle, or as a write out of order. These appear in the first cycle after the engine reaches a target. A bad stage count or byte alignment shows as missing, extra or corrupted write data once the commit runs. Other faults show up on the ready flag. A wrong busy-time load makes the flag rise early, or never rise, within tens of cycles. A failure to empty the buffer makes a repeated commit drop the flag when it should stay high.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  localparam logic [7:0] CMD_STAGE  = 8'h98;
  localparam logic [7:0] CMD_COMMIT = 8'h94;

  typedef enum logic [2:0] {
    DEC_IDLE,
    DEC_CMD,
    DEC_DATA,
    DEC_ADDR,
    DEC_SKIP
  } dec_state_e;
endpackage

// File: rtl/rrw_serial_rx.sv
module rrw_serial_rx #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_ni,
  input  logic       sclk_i,
  input  logic       sdi_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       frm_start_o,
  output logic       frm_end_o
);
  logic [SYNC_STAGES-1:0] req_sr, sclk_sr, sdi_sr;
  logic req_s, sclk_s, sdi_s, req_q, sclk_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] shreg_q;
  logic sclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sr  <= '1;
      sclk_sr <= '0;
      sdi_sr  <= '0;
    end else begin
      req_sr  <= {req_sr[SYNC_STAGES-2:0], req_ni};
      sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk_i};
      sdi_sr  <= {sdi_sr[SYNC_STAGES-2:0], sdi_i};
    end
  end

  assign req_s  = req_sr[SYNC_STAGES-1];
  assign sclk_s = sclk_sr[SYNC_STAGES-1];
  assign sdi_s  = sdi_sr[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      req_q  <= req_s;
      sclk_q <= sclk_s;
    end
  end

  assign frm_start_o = req_q & ~req_s;
  assign frm_end_o   = ~req_q & req_s;
  assign sclk_rise   = sclk_s & ~sclk_q & ~req_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (frm_start_o || frm_end_o) begin
        bit_cnt_q <= '0;  // partial byte dropped
      end else if (sclk_rise) begin
        shreg_q   <= {shreg_q[6:0], sdi_s};
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {shreg_q[6:0], sdi_s};
        end
      end
    end
  end

  AST_BYTE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(!req_s)); // R2
endmodule

// File: rtl/rrw_cmd_dec.sv
module rrw_cmd_dec
  import rrw_pkg::*;
#(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned MAX_WORDS = 16,
  localparam int unsigned IDX_W    = $clog2(MAX_WORDS),
  localparam int unsigned CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int unsigned BPW      = DATA_W / 8,
  localparam int unsigned BIDX_W   = (BPW > 1) ? $clog2(BPW) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              frm_start_i,
  input  logic              frm_end_i,
  input  logic              busy_i,
  output logic              push_o,
  output logic [IDX_W-1:0]  push_idx_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [CNT_W-1:0]  start_cnt_o
);
  dec_state_e state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIDX_W-1:0] bidx_q;
  logic [DATA_W-1:0] word_sr_q;
  logic [DATA_W-1:0] word_next;

  assign word_next = {word_sr_q[DATA_W-9:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= DEC_IDLE;
      cnt_q        <= '0;
      bidx_q       <= '0;
      word_sr_q    <= '0;
      push_o       <= 1'b0;
      push_idx_o   <= '0;
      push_data_o  <= '0;
      start_o      <= 1'b0;
      start_addr_o <= '0;
      start_cnt_o  <= '0;
    end else begin
      push_o  <= 1'b0;
      start_o <= 1'b0;
      if (frm_end_i) begin
        state_q <= DEC_IDLE;
      end else if (frm_start_i) begin
        state_q <= DEC_CMD;
      end else if (byte_vld_i) begin
        unique case (state_q)
          DEC_CMD: begin
            if (busy_i) begin
              state_q <= DEC_SKIP;
            end else if (byte_i == CMD_STAGE) begin
              state_q <= DEC_DATA;
              cnt_q   <= '0;
              bidx_q  <= '0;
            end else if (byte_i == CMD_COMMIT && cnt_q != '0) begin
              state_q <= DEC_ADDR;
            end else begin
              state_q <= DEC_SKIP;
            end
          end
          DEC_DATA: begin
            word_sr_q <= word_next;
            if (bidx_q == BIDX_W'(BPW - 1)) begin
              bidx_q <= '0;
              if (cnt_q < CNT_W'(MAX_WORDS)) begin
                push_o      <= 1'b1;
                push_idx_o  <= cnt_q[IDX_W-1:0];
                push_data_o <= word_next;
                cnt_q       <= cnt_q + CNT_W'(1);
              end
            end else begin
              bidx_q <= bidx_q + BIDX_W'(1);
            end
          end
          DEC_ADDR: begin
            start_o      <= 1'b1;
            start_addr_o <= byte_i[ADDR_W-1:0];
            start_cnt_o  <= cnt_q;
            cnt_q        <= '0;
            state_q      <= DEC_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  AST_STAGE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_WORDS)); // R4
  AST_COMMIT_NEEDS_WORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (start_cnt_o != '0) && $past(cnt_q != '0)); // R9
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(busy_i)); // R11
endmodule

// File: rtl/rrw_stage_buf.sv
module rrw_stage_buf #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned MAX_WORDS = 16,
  localparam int unsigned IDX_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [MAX_WORDS];

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))       mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/rrw_commit.sv
module rrw_commit #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned MAX_WORDS = 16,
  parameter int unsigned BUSY_STEP = 2,
  localparam int unsigned IDX_W    = $clog2(MAX_WORDS),
  localparam int unsigned CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int unsigned ROOM_W   = ADDR_W + 1,
  localparam int unsigned BUSY_W   = $clog2(MAX_WORDS * BUSY_STEP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_waddr_o,
  output logic [DATA_W-1:0] ram_wdata_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  n_q, k_q, lim;
  logic [BUSY_W-1:0] min_q;
  logic              busy_q, hit;
  logic [ROOM_W-1:0] room, tgt;

  // words that still fit below the top of the RAM
  assign room = ROOM_W'(1 << ADDR_W) - {1'b0, start_addr_i};
  assign lim  = (ROOM_W'(start_cnt_i) > room) ? CNT_W'(room) : start_cnt_i;
  assign tgt  = ROOM_W'(base_q) + ROOM_W'(k_q);
  assign hit  = busy_q && (k_q < n_q) && (tgt == {1'b0, exec_addr_i});
  assign rd_idx_o = k_q[IDX_W-1:0];
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q      <= '0;
      n_q         <= '0;
      k_q         <= '0;
      min_q       <= '0;
      busy_q      <= 1'b0;
      ram_we_o    <= 1'b0;
      ram_waddr_o <= '0;
      ram_wdata_o <= '0;
    end else begin
      ram_we_o <= 1'b0;
      if (start_i && !busy_q) begin
        base_q <= start_addr_i;
        n_q    <= lim;
        k_q    <= '0;
        min_q  <= BUSY_W'((MAX_WORDS - int'(start_cnt_i)) * BUSY_STEP);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (min_q != '0) min_q <= min_q - BUSY_W'(1);
        if (hit) begin
          ram_we_o    <= 1'b1;
          ram_waddr_o <= exec_addr_i;
          ram_wdata_o <= rd_data_i;
          k_q         <= k_q + CNT_W'(1);
        end else if (k_q == n_q && min_q == '0) begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  AST_WE_AT_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_waddr_o == $past(exec_addr_i)); // R6
  AST_WE_IN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o || ram_waddr_o == $past(ram_waddr_o) + ADDR_W'(1)); // R7
  AST_WE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> busy_q); // R8
  AST_MIN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(min_q) == '0); // R8
endmodule

// File: rtl/rram_rewrite_ctrl.sv
module rram_rewrite_ctrl #(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned MAX_WORDS   = 16,
  parameter int unsigned BUSY_STEP   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(MAX_WORDS),
  localparam int unsigned CNT_W      = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  output logic              rdy_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_waddr_o,
  output logic [DATA_W-1:0] ram_wdata_o
);
  logic              byte_vld, frm_start, frm_end, busy;
  logic [7:0]        byte_d;
  logic              push, start;
  logic [IDX_W-1:0]  push_idx, rd_idx;
  logic [DATA_W-1:0] push_data, rd_data;
  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  start_cnt;

  rrw_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni, .req_ni, .sclk_i, .sdi_i,
    .byte_vld_o(byte_vld), .byte_o(byte_d),
    .frm_start_o(frm_start), .frm_end_o(frm_end)
  );

  rrw_cmd_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) u_dec (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .byte_i(byte_d),
    .frm_start_i(frm_start), .frm_end_i(frm_end), .busy_i(busy),
    .push_o(push), .push_idx_o(push_idx), .push_data_o(push_data),
    .start_o(start), .start_addr_o(start_addr), .start_cnt_o(start_cnt)
  );

  rrw_stage_buf #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)) u_buf (
    .clk_i, .rst_ni,
    .we_i(push), .widx_i(push_idx), .wdata_i(push_data),
    .ridx_i(rd_idx), .rdata_o(rd_data)
  );

  rrw_commit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS),
               .BUSY_STEP(BUSY_STEP)) u_commit (
    .clk_i, .rst_ni,
    .start_i(start), .start_addr_i(start_addr), .start_cnt_i(start_cnt),
    .exec_addr_i, .rd_idx_o(rd_idx), .rd_data_i(rd_data),
    .busy_o(busy), .ram_we_o, .ram_waddr_o, .ram_wdata_o
  );

  assign rdy_o = ~busy;

  AST_RDY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !rdy_o); // R5
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> !ram_we_o); // R1
endmodule

// File: tb/rram_rewrite_ctrl_tb_top.sv
module rram_rewrite_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [5:0] exec = '0;
  logic rdy, we;
  logic [5:0] waddr;
  logic [23:0] wdata;
  int n_chk = 0, n_bad = 0;
  bit sweep = 1'b0;
  int wr_n = 0, low_cyc = 0;
  logic [5:0]  log_a [64];
  logic [23:0] log_d [64];

  always #10 clk = ~clk;

  rram_rewrite_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n), .sclk_i(sclk), .sdi_i(sdi),
    .exec_addr_i(exec), .rdy_o(rdy), .ram_we_o(we), .ram_waddr_o(waddr),
    .ram_wdata_o(wdata)
  );

  always @(negedge clk) begin
    if (we && wr_n < 64) begin
      log_a[wr_n] = waddr;
      log_d[wr_n] = wdata;
    end
    if (we) wr_n = wr_n + 1;
    if (!rdy) low_cyc = low_cyc + 1;
    if (sweep) exec = exec + 6'd1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [23:0] pat(input logic [23:0] s, input int i);
    return s + 24'h010203 * 24'(i);
  endfunction

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sdi = b[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic frm_open();
    req_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic frm_close();
    repeat (6) @(negedge clk);
    req_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic stage_frame(input int n, input logic [23:0] s);
    frm_open();
    send_byte(8'h98);
    for (int i = 0; i < n; i++) begin
      logic [23:0] w;
      w = pat(s, i);
      send_byte(w[23:16]);
      send_byte(w[15:8]);
      send_byte(w[7:0]);
    end
    frm_close();
  endtask

  task automatic commit_frame(input logic [7:0] a);
    frm_open();
    send_byte(8'h94);
    send_byte(a);
    frm_close();
  endtask

  task automatic wait_rdy(input string req);
    int t = 0;
    while (!rdy && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(rdy === 1'b1, req, int'(rdy), 1);
  endtask

  task automatic clr_log();
    wr_n = 0;
    low_cyc = 0;
  endtask

  task automatic t_reset();
    chk(rdy === 1'b1, "R1 rdy after reset", int'(rdy), 1);
    chk(we === 1'b0, "R1 we after reset", int'(we), 0);
  endtask

  task automatic t_basic();
    clr_log();
    sweep = 1'b1;
    stage_frame(5, 24'hA51200);
    commit_frame(8'd10);
    wait_rdy("R8 rdy back after basic commit");
    chk(wr_n == 5, "R6 write count basic", wr_n, 5);
    for (int i = 0; i < 5; i++) begin
      chk(log_a[i] == 6'(10 + i), "R6 addr basic", int'(log_a[i]), 10 + i);
      chk(log_d[i] == pat(24'hA51200, i), "R3 data basic", int'(log_d[i]), int'(pat(24'hA51200, i)));
    end
    chk(low_cyc >= 22, "R8 min busy n=5", low_cyc, 22);
    sweep = 1'b0;
  endtask

  task automatic t_order();
    clr_log();
    exec = 6'd21;
    stage_frame(3, 24'h300000);
    commit_frame(8'd20);
    repeat (40) @(negedge clk);
    chk(wr_n == 0, "R7 no write before first target", wr_n, 0);
    chk(rdy === 1'b0, "R8 rdy low while pending", int'(rdy), 0);
    exec = 6'd20;
    repeat (5) @(negedge clk);
    chk(wr_n == 1 && log_a[0] == 6'd20, "R6 first target written", wr_n, 1);
    exec = 6'd22;
    repeat (5) @(negedge clk);
    chk(wr_n == 1, "R7 skip ahead not written", wr_n, 1);
    exec = 6'd21;
    repeat (5) @(negedge clk);
    exec = 6'd22;
    repeat (5) @(negedge clk);
    chk(wr_n == 3, "R7 remaining in order", wr_n, 3);
    chk(log_a[1] == 6'd21 && log_a[2] == 6'd22, "R7 order addr", int'(log_a[2]), 22);
    exec = 6'd0;
    wait_rdy("R8 rdy after ordered commit");
  endtask

  task automatic t_full();
    clr_log();
    sweep = 1'b1;
    stage_frame(18, 24'h010000);
    commit_frame(8'd0);
    wait_rdy("R8 rdy after full commit");
    repeat (80) @(negedge clk);
    chk(wr_n == 16, "R4 only 16 words written", wr_n, 16);
    chk(log_a[15] == 6'd15 && log_d[15] == pat(24'h010000, 15), "R4 last word",
        int'(log_d[15]), int'(pat(24'h010000, 15)));
    sweep = 1'b0;
  endtask

  task automatic t_ignore();
    clr_log();
    sweep = 1'b1;
    commit_frame(8'd5);
    repeat (40) @(negedge clk);
    chk(rdy === 1'b1 && low_cyc == 0, "R9 commit with empty buffer", low_cyc, 0);
    frm_open();
    send_byte(8'h55);
    send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
    frm_close();
    commit_frame(8'd5);
    repeat (80) @(negedge clk);
    chk(low_cyc == 0 && wr_n == 0, "R9 unknown command ignored", wr_n, 0);
    sweep = 1'b0;
  endtask

  task automatic t_edge();
    clr_log();
    sweep = 1'b1;
    stage_frame(4, 24'h7E0000);
    commit_frame(8'd62);
    wait_rdy("R8 rdy after edge commit");
    repeat (80) @(negedge clk);
    chk(wr_n == 2, "R10 words past 63 dropped", wr_n, 2);
    chk(log_a[1] == 6'd63, "R10 last address", int'(log_a[1]), 63);
    sweep = 1'b0;
  endtask

  task automatic t_abort();
    clr_log();
    sweep = 1'b1;
    frm_open();
    send_byte(8'h98);
    send_byte(8'hC3); send_byte(8'h5A); send_byte(8'h81);
    send_bits(8'hFF, 5);
    frm_close();
    commit_frame(8'd30);
    wait_rdy("R2 rdy after abort commit");
    chk(wr_n == 1, "R2 abort frame word count", wr_n, 1);
    chk(log_a[0] == 6'd30 && log_d[0] == 24'hC35A81, "R2 MSB-first word after abort",
        int'(log_d[0]), 24'hC35A81);
    sweep = 1'b0;
  endtask

  task automatic t_restart();
    clr_log();
    sweep = 1'b1;
    stage_frame(2, 24'h111111);
    stage_frame(1, 24'h222222);
    commit_frame(8'd5);
    wait_rdy("R3 rdy after restart commit");
    chk(wr_n == 1 && log_d[0] == 24'h222222, "R3 second staging replaces first",
        int'(log_d[0]), 24'h222222);
    sweep = 1'b0;
  endtask

  task automatic t_rdy_timing();
    clr_log();
    exec = 6'd0;
    stage_frame(1, 24'h0ABCDE);
    frm_open();
    send_byte(8'h94);
    repeat (6) @(negedge clk);
    chk(rdy === 1'b1, "R5 rdy high after command byte", int'(rdy), 1);
    send_byte(8'd40);
    repeat (6) @(negedge clk);
    chk(rdy === 1'b0, "R5 rdy low after address byte", int'(rdy), 0);
    frm_close();
    // busy-time ignore: new frames while pending
    stage_frame(1, 24'hFFFFFF);
    commit_frame(8'd50);
    sweep = 1'b1;
    wait_rdy("R8 rdy after busy-ignore commit");
    repeat (80) @(negedge clk);
    chk(wr_n == 1 && log_a[0] == 6'd40 && log_d[0] == 24'h0ABCDE, "R11 frames during busy ignored",
        int'(log_d[0]), 24'h0ABCDE);
    low_cyc = 0;
    commit_frame(8'd50);
    repeat (80) @(negedge clk);
    chk(low_cyc == 0 && wr_n == 1, "R12 buffer emptied by commit", low_cyc, 0);
    sweep = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_full();
    t_ignore();
    t_edge();
    t_abort();
    t_restart();
    t_rdy_timing();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule